// File: doc/BRIEF.md
# A-law Sample Compressor and Expander

This block is a pair of streaming A-law converters that share a clock and a reset but nothing else. The compress channel accepts a 13-bit two's-complement audio sample and returns the 8-bit code that goes on the line. The expand channel accepts such a line code and returns a 13-bit signed sample. Each channel has its own input strobe and its own output strobe, and each has exactly one register stage.

The compressor takes the magnitude of the sample without adding any bias. Small magnitudes, up to 31, fall into a linear first segment. In that segment the step field is the magnitude shifted right by one. Larger magnitudes are placed by the position of their leading one. The segment number is that position minus four, and the step is the four bits just below the leading one. A magnitude too large for 12 bits is forced to the top code. The sign bit is set for negative samples. The even-numbered code bits are then inverted before the code leaves the block.

The expander removes that inversion pattern. It rebuilds the magnitude at the middle of the quantization interval the code stands for, and then applies the sign. A typical use is an encoder feeding a transport on one side and a decoder feeding a mixer on the other, both running every sample period.

Top module: `alaw_codec`

## Requirements
- R1: While rst_n is low at a clock edge, both output strobes and both output data words are cleared to zero on that edge.
- R2: A compressed sample with magnitude 0 to 31 gives segment field (code bits 6:4, before inversion) 0 and step field (bits 3:0) equal to the magnitude divided by two, rounded down.
- R3: A magnitude from 32 to 4095 with its leading one at bit k gives segment field k-4 and step field equal to magnitude bits k-1 down to k-4.
- R4: Code bit 7 is 1 when the input sample is negative and 0 when it is zero or positive. Bit 7 is not touched by the inversion pattern.
- R5: The compressor XORs its code with 8'h55 before output, and the expander XORs its input with 8'h55 before decoding.
- R6: A magnitude above 4095, which only the sample -4096 produces, saturates to segment 7, step 15.
- R7: In the expander, segment 0 rebuilds the magnitude as 2*step+1.
- R8: In the expander, segment s from 1 to 7 rebuilds the magnitude as (16+step)*2^s + 2^(s-1), which is the middle of the interval.
- R9: The expander output is the negated magnitude in two's complement when code bit 7 is 1, and the plain magnitude when it is 0.
- R10: Each channel's output strobe is its input strobe delayed by one clock. The output data is updated only on an accepted input and holds otherwise. Back-to-back inputs are accepted every cycle.
- R11: Activity on one channel never changes the other channel's output strobe or output data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both channels |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_in_valid | input | 1 | Compress channel input strobe |
| enc_sample | input | 13 | Sample to compress, two's complement |
| enc_out_valid | output | 1 | Compress channel output strobe |
| enc_code | output | 8 | Compressed line code |
| dec_in_valid | input | 1 | Expand channel input strobe |
| dec_code | input | 8 | Line code to expand |
| dec_out_valid | output | 1 | Expand channel output strobe |
| dec_sample | output | 13 | Expanded sample, two's complement |

## Verification
The bench goes after the edges between segments: 31 against 32, 63 against 64, and the largest magnitude, 4095. A design with an off-by-one in the leading-one search would put these in the wrong segment. The sample -4096 is checked for saturation, because a design that ignores the 13th magnitude bit would wrap it to code zero. Negative values near zero are checked to catch a polarity sense that is reversed or masked by the inversion. On the expand side, codes in segment 0 and in the top segment show whether the midpoint is placed wrongly or lost, for example 4032 coming back as 3968. Idle cycles and one-sided traffic show whether a channel updates without its strobe or leaks into the other channel.

// File: rtl/alaw_pkg.sv
package alaw_pkg;
    // Widths of the sample, its magnitude and the code fields
    parameter int SAMPLE_W = 13;
    parameter int MAG_W    = 12;
    parameter int CHORD_W  = 3;
    parameter int STEP_W   = 4;
    parameter logic [7:0] INV_MASK = 8'h55;

    localparam int CODE_W     = 1 + CHORD_W + STEP_W;
    localparam int LIN_TOP    = STEP_W + 1;          // highest bit position of the linear segment
    localparam int LIN_MAX    = (1 << LIN_TOP) - 1;  // largest magnitude in segment 0
    localparam int CHORD_MAX  = (1 << CHORD_W) - 1;
    localparam int STEP_MAX   = (1 << STEP_W) - 1;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [CODE_W-1:0]   code_t;

    typedef struct packed {
        logic               neg;
        logic [CHORD_W-1:0] chord;
        logic [STEP_W-1:0]  step;
    } fields_t;

    typedef struct packed {
        logic    enc_v;
        code_t   enc_code;
        logic    dec_v;
        sample_t dec_sample;
    } codec_state_t;
endpackage

// File: rtl/alaw_compress_core.sv
module alaw_compress_core
    import alaw_pkg::*;
(
    input  sample_t sample_i,
    output code_t   code_o
);
    sample_t mag_d;
    logic    sat_d;
    fields_t fld_d;

    always_comb begin
        mag_d = sample_i[SAMPLE_W-1] ? (~sample_i + SAMPLE_W'(1)) : sample_i;
        sat_d = (mag_d > sample_t'((1 << MAG_W) - 1));
        fld_d.neg   = sample_i[SAMPLE_W-1];
        fld_d.chord = '0;
        fld_d.step  = mag_d[STEP_W:1];
        if (sat_d) begin
            fld_d.chord = CHORD_W'(CHORD_MAX);
            fld_d.step  = STEP_W'(STEP_MAX);
        end else begin
            // ascending scan: the highest set bit wins
            for (int p = LIN_TOP; p < MAG_W; p++) begin
                if (mag_d[p]) begin
                    fld_d.chord = CHORD_W'(p - STEP_W);
                    fld_d.step  = STEP_W'(mag_d >> (p - STEP_W));
                end
            end
        end
        code_o = code_t'(fld_d) ^ INV_MASK;
    end

    // R3: outside saturation, a nonzero segment means the leading one sits at segment+4
    always_comb begin
        if (!sat_d && fld_d.chord != '0)
            a_r3_lead_pos: assert ((mag_d >> (fld_d.chord + STEP_W)) == sample_t'(1));
    end
endmodule

// File: rtl/alaw_expand_core.sv
module alaw_expand_core
    import alaw_pkg::*;
(
    input  code_t   code_i,
    output sample_t sample_o
);
    fields_t fld_d;
    sample_t mag_d;

    always_comb begin
        fld_d = fields_t'(code_i ^ INV_MASK);
        if (fld_d.chord == '0) begin
            mag_d = sample_t'({fld_d.step, 1'b1});
        end else begin
            mag_d = sample_t'({1'b1, fld_d.step}) << fld_d.chord;
            mag_d = mag_d | (sample_t'(1) << (fld_d.chord - 1'b1));
        end
        sample_o = fld_d.neg ? (~mag_d + SAMPLE_W'(1)) : mag_d;
    end

    // R8: rebuilt magnitude always lies inside the representable 12-bit range and is nonzero
    always_comb begin
        a_r8_mag_range: assert (mag_d != '0 && mag_d < sample_t'(1 << MAG_W));
    end
endmodule

// File: rtl/alaw_codec.sv
module alaw_codec
    import alaw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enc_in_valid,
    input  logic [12:0]         enc_sample,
    output logic                enc_out_valid,
    output logic [7:0]          enc_code,
    input  logic                dec_in_valid,
    input  logic [7:0]          dec_code,
    output logic                dec_out_valid,
    output logic [12:0]         dec_sample
);
    code_t        enc_code_d;
    sample_t      dec_sample_d;
    codec_state_t state_d, state_q;

    alaw_compress_core u_cmp (
        .sample_i (enc_sample),
        .code_o   (enc_code_d)
    );

    alaw_expand_core u_exp (
        .code_i   (dec_code),
        .sample_o (dec_sample_d)
    );

    always_comb begin
        state_d       = state_q;
        state_d.enc_v = enc_in_valid;
        state_d.dec_v = dec_in_valid;
        if (enc_in_valid) state_d.enc_code   = enc_code_d;
        if (dec_in_valid) state_d.dec_sample = dec_sample_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign enc_out_valid = state_q.enc_v;
    assign enc_code      = state_q.enc_code;
    assign dec_out_valid = state_q.dec_v;
    assign dec_sample    = state_q.dec_sample;

    // R10: strobes follow their inputs one clock later, data holds when idle
    a_r10_enc_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        enc_in_valid |=> enc_out_valid);
    a_r10_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_in_valid |=> (!enc_out_valid && $stable(enc_code)));
    a_r10_dec_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        dec_in_valid |=> dec_out_valid);
    a_r10_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_in_valid |=> (!dec_out_valid && $stable(dec_sample)));
    // R4: polarity bit follows the sample sign
    a_r4_enc_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        enc_in_valid |=> (enc_code[7] == $past(enc_sample[12])));
    // R9: expanded sign follows the polarity bit
    a_r9_dec_sign: assert property (@(posedge clk) disable iff (!rst_n)
        dec_in_valid |=> (dec_sample[12] == $past(dec_code[7])));
endmodule

// File: tb/sim_alaw_codec.sv
`timescale 1ns/1ps
module sim_alaw_codec;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enc_in_valid, dec_in_valid;
    logic [12:0] enc_sample;
    logic [7:0]  dec_code;
    logic        enc_out_valid, dec_out_valid;
    logic [7:0]  enc_code;
    logic [12:0] dec_sample;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    alaw_codec u0 (
        .clk(clk), .rst_n(rst_n),
        .enc_in_valid(enc_in_valid), .enc_sample(enc_sample),
        .enc_out_valid(enc_out_valid), .enc_code(enc_code),
        .dec_in_valid(dec_in_valid), .dec_code(dec_code),
        .dec_out_valid(dec_out_valid), .dec_sample(dec_sample)
    );

    localparam int NE = 14;
    localparam logic [12:0] ENC_S [NE] = '{13'd0, 13'd1, 13'd31, 13'd32, 13'd33, 13'd63,
        13'd64, 13'd100, 13'd1000, 13'd4095, 13'h1FFF, 13'h1C18, 13'h1000, 13'h1001};
    localparam logic [7:0] ENC_C [NE] = '{8'h55, 8'h55, 8'h5A, 8'h45, 8'h45, 8'h4A,
        8'h75, 8'h7C, 8'h0A, 8'h2A, 8'hD5, 8'h8A, 8'hAA, 8'hAA};
    localparam int ENC_T [NE] = '{5, 2, 2, 3, 3, 3, 3, 3, 3, 3, 4, 4, 6, 6};

    localparam int ND = 10;
    localparam logic [7:0] DEC_C [ND] = '{8'h55, 8'h5A, 8'h54, 8'h45, 8'h7C, 8'h0A,
        8'h2A, 8'hD5, 8'hD4, 8'hAA};
    localparam logic [12:0] DEC_S [ND] = '{13'd1, 13'd31, 13'd3, 13'd33, 13'd102, 13'd1008,
        13'd4032, 13'h1FFF, 13'h1FFD, 13'h1040};
    localparam int DEC_T [ND] = '{7, 7, 5, 8, 8, 8, 8, 9, 9, 9};

    function automatic string req_name(int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; enc_in_valid = 1'b0; dec_in_valid = 1'b0;
        enc_sample = '0; dec_code = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", 13'(enc_out_valid), 13'd0);
        chk("R1", 13'(enc_code), 13'd0);
        chk("R1", 13'(dec_out_valid), 13'd0);
        chk("R1", dec_sample, 13'd0);
        @(negedge clk) rst_n = 1'b1;

        // compress table, one sample per cycle (R10 back-to-back)
        for (int i = 0; i < NE; i++) begin
            @(negedge clk);
            enc_in_valid = 1'b1; enc_sample = ENC_S[i];
            @(posedge clk); #1;
            chk("R10", 13'(enc_out_valid), 13'd1);
            chk(req_name(ENC_T[i]), 13'(enc_code), 13'(ENC_C[i]));
        end
        // R10: idle cycle holds the last code
        @(negedge clk); enc_in_valid = 1'b0; enc_sample = 13'd1000;
        @(posedge clk); #1;
        chk("R10", 13'(enc_out_valid), 13'd0);
        chk("R10", 13'(enc_code), 13'h0AA);

        // expand table
        for (int i = 0; i < ND; i++) begin
            @(negedge clk);
            dec_in_valid = 1'b1; dec_code = DEC_C[i];
            @(posedge clk); #1;
            chk("R10", 13'(dec_out_valid), 13'd1);
            chk(req_name(DEC_T[i]), dec_sample, DEC_S[i]);
        end
        // R11: compress side untouched by expand traffic
        chk("R11", 13'(enc_code), 13'h0AA);
        chk("R11", 13'(enc_out_valid), 13'd0);
        @(negedge clk); dec_in_valid = 1'b0; dec_code = 8'h55;
        @(posedge clk); #1;
        chk("R10", 13'(dec_out_valid), 13'd0);
        chk("R10", dec_sample, 13'h1040);

        // both channels in the same cycle
        @(negedge clk);
        enc_in_valid = 1'b1; enc_sample = 13'd100;
        dec_in_valid = 1'b1; dec_code = 8'h45;
        @(posedge clk); #1;
        chk("R11", 13'(enc_code), 13'h07C);
        chk("R11", dec_sample, 13'd33);

        // R11: only the compress side moves
        @(negedge clk);
        dec_in_valid = 1'b0; dec_code = 8'hAA;
        enc_sample = 13'd4095;
        @(posedge clk); #1;
        chk("R11", 13'(dec_out_valid), 13'd0);
        chk("R11", dec_sample, 13'd33);
        chk("R3", 13'(enc_code), 13'h02A);

        // R1: reset in mid-run clears everything
        @(negedge clk); enc_in_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1", 13'(enc_code), 13'd0);
        chk("R1", dec_sample, 13'd0);
        chk("R1", 13'(enc_out_valid), 13'd0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule